// File: doc/BRIEF.md
# Multi-channel conversion result sequencer

This block stands in for the digital output side of a simultaneous-sampling converter, so that a readout controller can be verified against it. Software or a bench first loads one data word per channel into a small sample store and sets how many channels a burst covers. A rising edge on the start input launches a burst. The block then lowers its active-low end-of-conversion strobe on a fixed cycle schedule: sixteen conversion-clock edges after the start edge for the first channel, and three edges later for each channel after that. The final channel's strobe comes together with an active-low end-of-last-conversion flag.

A read is a clock edge at which both the active-low read and active-low chip-select inputs are low. One edge later the block raises its bus-enable output and drives the word of the most recently announced channel. When no read is taking place, the bus stays at zero with the enable low. A read releases a pending strobe at once. A strobe that nobody reads lasts two cycles and is then released ahead of the next channel. While a burst runs, the block reports busy and ignores new start edges and all configuration writes, so the data under conversion stays fixed.

Top module: `convseq_model`

## Requirements
- R1: After the clock edge that samples a rising start edge (edge k), `eoc_n` is first low right after edge k+16 and is never low while `busy` is low.
- R2: Channel i (counting from 0) lowers `eoc_n` right after edge k+16+3i. Without a read, the strobe stays low for two cycles and is high for the cycle before the next channel.
- R3: `eolc_n` is low exactly when `eoc_n` is low for the last channel of the burst, and high at all other times.
- R4: A read (`rd_n` and `cs_n` both low at an edge) sets `bus_oe` to 1 after that edge, and `bus_data` then carries the stored word of the most recently announced channel. Without a read, `bus_oe` is 0 and `bus_data` is 0 after the edge. `rd_n` low with `cs_n` high is not a read.
- R5: A read at an edge where `eoc_n` is low makes `eoc_n` high after that edge.
- R6: `busy` goes high after edge k and falls after edge k+3N+15. A start edge seen while busy is ignored.
- R7: Writes to the sample store and to the channel-count register are ignored while `busy` is high.
- R8: A channel-count write stores the value limited to the range 1 to NCH_MAX: 0 becomes 1, and values above NCH_MAX become NCH_MAX.
- R9: If results are not read, each new channel replaces the previous one, and a later read returns the word of the last channel announced.
- R10: During and after a synchronous reset, `eoc_n` and `eolc_n` are high, and `busy`, `bus_oe` and `bus_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion start; a rising edge launches a burst |
| rd_n | input | 1 | Active-low read strobe |
| cs_n | input | 1 | Active-low chip select |
| smp_we | input | 1 | Sample store write enable |
| smp_addr | input | AW | Channel index of the sample being written |
| smp_data | input | DATA_W | Sample word to store |
| nch_we | input | 1 | Channel-count write enable |
| nch_val | input | NW | Requested number of channels per burst |
| eoc_n | output | 1 | Active-low end-of-conversion strobe |
| eolc_n | output | 1 | Active-low end-of-last-conversion flag |
| busy | output | 1 | Burst in progress |
| bus_oe | output | 1 | Data bus drive enable |
| bus_data | output | DATA_W | Data bus, zero when not driven |

## Verification
The bench builds the block with NCH_MAX = 4, which gives a 2-bit address and a 3-bit count field. With this setting, every legal channel count and both clamp directions (0 and 7) fit into a short run. For each count, it compares the strobe, last-flag and busy outputs on every cycle of the burst against the 16 + 3i schedule worked out in the bench. These bursts also carry a repeated start edge and configuration writes in the middle. Separate bursts read every channel in turn to check bus data, release timing and ignored store writes. Unread bursts are followed by a read, which checks that the last channel's word wins.

// File: rtl/convseq_pkg.sv
package convseq_pkg;
  // fixed conversion schedule, in conversion-clock edges
  localparam int FIRST_LAT = 16;
  localparam int CH_STEP   = 3;

  // edges from the start edge to the end of a burst of n channels
  function automatic int burst_span(input int n);
    return FIRST_LAT + CH_STEP * (n - 1) + 2;
  endfunction
endpackage

// File: rtl/convseq_store.sv
module convseq_store #(
  parameter int DATA_W  = 14,
  parameter int NCH_MAX = 8,
  parameter int AW      = 3,
  parameter int NW      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              smp_we,
  input  logic [AW-1:0]     smp_addr,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              nch_we,
  input  logic [NW-1:0]     nch_val,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [NW-1:0]     nch_cfg,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [NW-1:0] NMAX = NW'(NCH_MAX);

  logic [DATA_W-1:0] mem [NCH_MAX];

  // write port: no reset, so the array can map onto block RAM
  always_ff @(posedge clk) begin
    if (smp_we && !busy && (32'(smp_addr) < NCH_MAX))
      mem[smp_addr] <= smp_data;
  end

  // read port with enable and synchronous output clear
  always_ff @(posedge clk) begin
    if (rst || !rd_en)
      rdata <= '0;
    else
      rdata <= mem[rd_addr];
  end

  // channel count register, limited to 1..NCH_MAX
  always_ff @(posedge clk) begin
    if (rst)
      nch_cfg <= NMAX;
    else if (nch_we && !busy) begin
      if (nch_val == '0)
        nch_cfg <= NW'(1);
      else if (nch_val > NMAX)
        nch_cfg <= NMAX;
      else
        nch_cfg <= nch_val;
    end
  end
endmodule

// File: rtl/convseq_sched.sv
module convseq_sched
  import convseq_pkg::*;
#(
  parameter int NCH_MAX = 8,
  parameter int AW      = 3,
  parameter int NW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          rd_req,
  input  logic [NW-1:0] nch_cfg,
  output logic          busy,
  output logic          eoc_n,
  output logic          eolc_n,
  output logic [AW-1:0] ch_avail
);
  localparam int CW = $clog2(FIRST_LAT + CH_STEP * NCH_MAX + 4);
  localparam logic [CW-1:0] T0   = CW'(FIRST_LAT - 1);
  localparam logic [CW-1:0] STEP = CW'(CH_STEP);

  logic          start_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] tgt;
  logic [NW-1:0] idx;
  logic [NW-1:0] n_act;
  logic          at_tgt;
  logic          pre_tgt;

  assign at_tgt  = (cnt == tgt) && (idx < n_act);
  assign pre_tgt = (cnt == tgt - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      tgt      <= T0;
      idx      <= '0;
      n_act    <= NW'(1);
      eoc_n    <= 1'b1;
      eolc_n   <= 1'b1;
      ch_avail <= '0;
    end else begin
      start_q <= start;
      if (!busy) begin
        if (start && !start_q) begin
          busy  <= 1'b1;
          cnt   <= '0;
          tgt   <= T0;
          idx   <= '0;
          n_act <= nch_cfg;
        end
      end else begin
        cnt <= cnt + CW'(1);
        if (at_tgt) begin
          eoc_n    <= 1'b0;
          eolc_n   <= (idx != n_act - NW'(1));
          ch_avail <= idx[AW-1:0];
          idx      <= idx + NW'(1);
          tgt      <= tgt + STEP;
        end else begin
          if (pre_tgt || (rd_req && !eoc_n)) begin
            eoc_n  <= 1'b1;
            eolc_n <= 1'b1;
          end
          if (pre_tgt && (idx == n_act))
            busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/convseq_bus.sv
module convseq_bus (
  input  logic clk,
  input  logic rst,
  input  logic rd_n,
  input  logic cs_n,
  output logic rd_req,
  output logic bus_oe
);
  assign rd_req = !rd_n && !cs_n;

  always_ff @(posedge clk) begin
    if (rst)
      bus_oe <= 1'b0;
    else
      bus_oe <= rd_req;
  end
endmodule

// File: rtl/convseq_model.sv
module convseq_model #(
  parameter int DATA_W  = 14,
  parameter int NCH_MAX = 8,
  parameter int AW      = (NCH_MAX > 1) ? $clog2(NCH_MAX) : 1,
  parameter int NW      = $clog2(NCH_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_n,
  input  logic              cs_n,
  input  logic              smp_we,
  input  logic [AW-1:0]     smp_addr,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              nch_we,
  input  logic [NW-1:0]     nch_val,
  output logic              eoc_n,
  output logic              eolc_n,
  output logic              busy,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_data
);
  logic          rd_req;
  logic [NW-1:0] nch_cfg;
  logic [AW-1:0] ch_avail;

  convseq_bus u_bus (
    .clk    (clk),
    .rst    (rst),
    .rd_n   (rd_n),
    .cs_n   (cs_n),
    .rd_req (rd_req),
    .bus_oe (bus_oe)
  );

  convseq_store #(
    .DATA_W (DATA_W),
    .NCH_MAX(NCH_MAX),
    .AW     (AW),
    .NW     (NW)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .smp_we  (smp_we),
    .smp_addr(smp_addr),
    .smp_data(smp_data),
    .nch_we  (nch_we),
    .nch_val (nch_val),
    .rd_en   (rd_req),
    .rd_addr (ch_avail),
    .nch_cfg (nch_cfg),
    .rdata   (bus_data)
  );

  convseq_sched #(
    .NCH_MAX(NCH_MAX),
    .AW     (AW),
    .NW     (NW)
  ) u_sched (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .rd_req  (rd_req),
    .nch_cfg (nch_cfg),
    .busy    (busy),
    .eoc_n   (eoc_n),
    .eolc_n  (eolc_n),
    .ch_avail(ch_avail)
  );
endmodule

// File: rtl/convseq_chk.sv
module convseq_chk #(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_n,
  input logic              cs_n,
  input logic              eoc_n,
  input logic              eolc_n,
  input logic              busy,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_data
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> eoc_n);

  p_strobe_in_burst_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(eoc_n) |-> busy);

  p_last_with_eoc_r3: assert property (@(posedge clk) disable iff (rst)
    !eolc_n |-> !eoc_n);

  p_oe_from_read_r4: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !cs_n) |=> bus_oe);

  p_bus_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_data == '0));

  p_read_release_r5: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !cs_n && !eoc_n) |=> eoc_n);

  p_burst_opens_clean_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (eoc_n && eolc_n));
endmodule

bind convseq_model convseq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_n    (rd_n),
  .cs_n    (cs_n),
  .eoc_n   (eoc_n),
  .eolc_n  (eolc_n),
  .busy    (busy),
  .bus_oe  (bus_oe),
  .bus_data(bus_data)
);

// File: tb/convseq_model_bench.sv
module convseq_model_bench;
  localparam int DW   = 14;
  localparam int NMAX = 4;
  localparam int AW   = 2;
  localparam int NW   = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          rd_n = 1'b1;
  logic          cs_n = 1'b1;
  logic          smp_we = 1'b0;
  logic [AW-1:0] smp_addr = '0;
  logic [DW-1:0] smp_data = '0;
  logic          nch_we = 1'b0;
  logic [NW-1:0] nch_val = '0;
  logic          eoc_n, eolc_n, busy, bus_oe;
  logic [DW-1:0] bus_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_mem [NMAX];

  convseq_model #(.DATA_W(DW), .NCH_MAX(NMAX)) u_convseq_model (
    .clk(clk), .rst(rst), .start(start), .rd_n(rd_n), .cs_n(cs_n),
    .smp_we(smp_we), .smp_addr(smp_addr), .smp_data(smp_data),
    .nch_we(nch_we), .nch_val(nch_val), .eoc_n(eoc_n), .eolc_n(eolc_n),
    .busy(busy), .bus_oe(bus_oe), .bus_data(bus_data)
  );

  always #4 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_smp(input int a, input int d);
    smp_we = 1'b1; smp_addr = AW'(a); smp_data = DW'(d);
    step(1);
    smp_we = 1'b0;
  endtask

  task automatic set_nch(input int v);
    nch_we = 1'b1; nch_val = NW'(v);
    step(1);
    nch_we = 1'b0;
  endtask

  // burst with no reads; per-cycle comparison against the schedule
  task automatic run_plain(input int n);
    start = 1'b1;
    for (int j = 0; j <= 3 * n + 16; j++) begin
      int ph;
      bit lo;
      step(1);
      ph = j - 16;
      lo = (j >= 16) && ((ph % 3) != 2) && ((ph / 3) < n);
      chk("R1/R2 eoc_n", int'(eoc_n), lo ? 0 : 1);
      chk("R3 eolc_n", int'(eolc_n), (lo && (ph / 3 == n - 1)) ? 0 : 1);
      chk("R6 busy", int'(busy), (j < 3 * n + 15) ? 1 : 0);
      // R6: a repeated start edge mid-burst must not restart it
      if (j == 3) start = 1'b0;
      if (j == 5) start = 1'b1;
      if (j == 8) start = 1'b0;
      // R7: writes during the burst must not land
      smp_we = (j == 4); smp_addr = '0; smp_data = DW'(16'h3FFF);
      nch_we = (j == 4); nch_val = NW'(1 + (n % 3));
    end
    smp_we = 1'b0; nch_we = 1'b0;
    // R9: late read returns the last channel announced
    rd_n = 1'b0; cs_n = 1'b0;
    step(1);
    chk("R9 bus_oe", int'(bus_oe), 1);
    chk("R9 bus_data", int'(bus_data), exp_mem[n - 1]);
    rd_n = 1'b1; cs_n = 1'b1;
    step(1);
    chk("R4 bus_oe idle", int'(bus_oe), 0);
    chk("R4 bus_data idle", int'(bus_data), 0);
  endtask

  // burst with a read of every channel
  task automatic run_read(input int n);
    start = 1'b1;
    step(1);
    start = 1'b0;
    smp_we = 1'b1; smp_addr = AW'(1); smp_data = DW'(16'h2AAA);
    step(1);
    smp_we = 1'b0;
    step(14);
    chk("R1 eoc_n before first", int'(eoc_n), 1);
    for (int i = 0; i < n; i++) begin
      step(1);
      chk("R2 eoc_n low", int'(eoc_n), 0);
      chk("R3 eolc_n", int'(eolc_n), (i == n - 1) ? 0 : 1);
      rd_n = 1'b0; cs_n = 1'b0;
      step(1);
      chk("R5 eoc_n released", int'(eoc_n), 1);
      chk("R4 bus_oe", int'(bus_oe), 1);
      chk("R4/R7 bus_data", int'(bus_data), exp_mem[i]);
      rd_n = 1'b1; cs_n = 1'b1;
      step(1);
      chk("R4 bus_oe off", int'(bus_oe), 0);
      chk("R4 bus_data off", int'(bus_data), 0);
    end
    chk("R6 busy end", int'(busy), 0);
  endtask

  initial begin
    step(3);
    chk("R10 eoc_n", int'(eoc_n), 1);
    chk("R10 eolc_n", int'(eolc_n), 1);
    chk("R10 busy", int'(busy), 0);
    chk("R10 bus_oe", int'(bus_oe), 0);
    chk("R10 bus_data", int'(bus_data), 0);
    rst = 1'b0;
    step(1);
    for (int i = 0; i < NMAX; i++) begin
      exp_mem[i] = (i * 32'h1235 + 32'h0A5) & 32'h3FFF;
      wr_smp(i, exp_mem[i]);
    end
    // R4: read strobe without chip select is not a read
    rd_n = 1'b0; cs_n = 1'b1;
    step(2);
    chk("R4 no cs bus_oe", int'(bus_oe), 0);
    rd_n = 1'b1;
    step(1);
    // R8: written values and their clamped effect; each run twice (R7 on count)
    for (int v = 0; v <= 7; v++) begin
      int eff;
      eff = (v == 0) ? 1 : ((v > NMAX) ? NMAX : v);
      if (v == 5 || v == 6) continue;
      set_nch(v);
      run_plain(eff);
      step(2);
      run_plain(eff);
      step(2);
    end
    for (int n = 1; n <= NMAX; n++) begin
      set_nch(n);
      run_read(n);
      step(2);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule